// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers pulsed requests from a set of peripheral interrupt sources and a small group of nonmaskable trap sources, and turns them into a single request toward a processor. Each peripheral source carries an enable bit and a three-level user priority. On every cycle the block picks one winner among the pending sources and checks that winner against the processor's current priority. It then presents the winner's vector number and the program-memory address of that vector's table entry.

Traps sit at the bottom of the vector space, ahead of all peripheral sources, and are never masked. A table-select bit in the control word moves every lookup, for traps and for interrupts alike, from the primary vector table to an alternate one that has the same layout. The processor acknowledges a vector by number, and that clears the matching pending flag. Reading the handler address out of memory, saving context and the processor's own reset path are handled elsewhere.

Top module: `vpic`

## Requirements
- R1: While `rst_n` is low, `cpu_req`, `vec_num` and `vec_addr` are all zero, and every pending flag, enable, priority and the table select are cleared.
- R2: A one-cycle pulse on `trap_req[t]` or `irq_req[i]` sets that source's pending flag at the clock edge that samples it. `cpu_req` and the vector outputs reflect that pending state at the next clock edge.
- R3: Any pending trap wins over every peripheral source, whatever that source's priority and whatever `cpu_ipl` is, including `cpu_ipl` = 7.
- R4: A peripheral source is eligible only when it is pending, its enable bit is 1 and its priority is strictly greater than `cpu_ipl`. Priority 0 therefore never requests.
- R5: Among pending traps, the lowest trap index wins. Among eligible sources, the highest priority wins, and a tie goes to the lower vector number.
- R6: Trap t has vector number t. Peripheral source i has vector number N_TRAP + i (with the defaults, 8 + i).
- R7: With the table select clear, `vec_addr` equals 0x000004 + 2 × `vec_num`.
- R8: With bit 15 of the control word set, `vec_addr` equals 0x000104 + 2 × `vec_num` for traps and for interrupts alike.
- R9: `ack` with `ack_vec` = v clears pending flag v at that edge. If a new request for v arrives in the same cycle, the flag stays set. Other flags are not touched.
- R10: When no source is eligible, `cpu_req` goes low and `vec_num` and `vec_addr` keep their previous values.
- R11: A write with `cfg_addr` = 0 loads the table select from `cfg_wdata[15]`. A write with `cfg_addr` = 1 + i loads source i's enable from `cfg_wdata[3]` and its priority from `cfg_wdata[2:0]`. Writes to addresses above N_SRC have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | N_TRAP | Trap request pulses, bit t for trap t |
| irq_req | input | N_SRC | Peripheral request pulses, bit i for source i |
| cpu_ipl | input | 3 | Current processor priority |
| ack | input | 1 | Acknowledge strobe |
| ack_vec | input | VW | Vector number being acknowledged |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| cpu_req | output | 1 | Request toward the processor |
| vec_num | output | VW | Winning vector number |
| vec_addr | output | 24 | Program address of the winning vector's table entry |

## Verification
A request pulse is registered into pending at the edge that samples it, and the outputs follow one edge later, so request-to-output takes two edges. An acknowledge or a configuration write takes effect at its own edge, and the outputs show the change one edge after that. The bench's behavioural model applies exactly this order on every rising edge: it first forms the outputs from the old state, then applies acknowledges, requests and writes. Outputs are compared a fifth of a period after each rising edge. The directed checks wait two falling edges after each stimulus before they sample.

// File: rtl/vpic.sv
module vpic #(
  parameter int          N_TRAP   = 8,
  parameter int          N_SRC    = 118,
  parameter logic [23:0] PRI_BASE = 24'h000004,
  parameter logic [23:0] ALT_BASE = 24'h000104,
  parameter int          ALT_BIT  = 15,
  localparam int NV = N_TRAP + N_SRC,
  localparam int VW = $clog2(NV),
  localparam int AW = $clog2(N_SRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRAP-1:0] trap_req,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [2:0]        cpu_ipl,
  input  logic              ack,
  input  logic [VW-1:0]     ack_vec,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic              cpu_req,
  output logic [VW-1:0]     vec_num,
  output logic [23:0]       vec_addr
);

  logic [N_TRAP-1:0] trap_pend;
  logic [N_SRC-1:0]  irq_pend;
  logic [N_SRC-1:0]  irq_en;
  logic [2:0]        irq_pri [N_SRC];
  logic              alt_sel;

  always_ff @(posedge clk)
    if (!rst_n)                          alt_sel <= 1'b0;
    else if (cfg_we && cfg_addr == '0)   alt_sel <= cfg_wdata[ALT_BIT];

  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    localparam logic [VW-1:0] TV = VW'(t);
    always_ff @(posedge clk)
      if (!rst_n)                        trap_pend[t] <= 1'b0;
      else if (trap_req[t])              trap_pend[t] <= 1'b1;
      else if (ack && ack_vec == TV)     trap_pend[t] <= 1'b0;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam logic [VW-1:0] SV = VW'(N_TRAP + i);
    localparam logic [AW-1:0] CA = AW'(i + 1);
    always_ff @(posedge clk)
      if (!rst_n)                        irq_pend[i] <= 1'b0;
      else if (irq_req[i])               irq_pend[i] <= 1'b1;
      else if (ack && ack_vec == SV)     irq_pend[i] <= 1'b0;
    always_ff @(posedge clk)
      if (!rst_n) begin
        irq_en[i]  <= 1'b0;
        irq_pri[i] <= 3'd0;
      end else if (cfg_we && cfg_addr == CA) begin
        irq_en[i]  <= cfg_wdata[3];
        irq_pri[i] <= cfg_wdata[2:0];
      end
  end

  logic          win_any;
  logic [VW-1:0] win_vec;
  logic [2:0]    best;

  always_comb begin
    win_any = 1'b0;
    win_vec = '0;
    best    = 3'd0;
    for (int t = N_TRAP - 1; t >= 0; t--)
      if (trap_pend[t]) begin
        win_any = 1'b1;
        win_vec = VW'(t);
      end
    if (trap_pend == '0)
      for (int i = 0; i < N_SRC; i++)
        if (irq_pend[i] && irq_en[i] && irq_pri[i] > cpu_ipl && irq_pri[i] > best) begin
          best    = irq_pri[i];
          win_any = 1'b1;
          win_vec = VW'(N_TRAP + i);
        end
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      cpu_req  <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
    end else begin
      cpu_req <= win_any;
      if (win_any) begin
        vec_num  <= win_vec;
        vec_addr <= (alt_sel ? ALT_BASE : PRI_BASE) + (24'(win_vec) << 1);
      end
    end

  logic [NV-1:0] req_all, pend_all;
  assign req_all  = {irq_req, trap_req};
  assign pend_all = {irq_pend, trap_pend};

  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend != '0) |=> (cpu_req && vec_num < VW'(N_TRAP))); // R3

  AST_MASK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pend == '0 && cpu_ipl == 3'd7) |=> !cpu_req); // R4

  AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> vec_addr == (($past(alt_sel)) ? ALT_BASE : PRI_BASE) + (24'(vec_num) << 1)); // R8

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_vec < VW'(NV) && !req_all[ack_vec]) |=> !pend_all[$past(ack_vec)]); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_any |=> (!cpu_req && $stable(vec_num) && $stable(vec_addr))); // R10

endmodule

// File: tb/vpic_tb.sv
module vpic_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int NS = 118;
  localparam int VW = 7;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0;
  logic [NT-1:0] trap_req = '0;
  logic [NS-1:0] irq_req = '0;
  logic [2:0] cpu_ipl = 0;
  logic ack = 0;
  logic [VW-1:0] ack_vec = 0;
  logic cfg_we = 0;
  logic [AW-1:0] cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic cpu_req;
  logic [VW-1:0] vec_num;
  logic [23:0] vec_addr;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  vpic u_dut (.clk, .rst_n, .trap_req, .irq_req, .cpu_ipl, .ack, .ack_vec,
              .cfg_we, .cfg_addr, .cfg_wdata, .cpu_req, .vec_num, .vec_addr);

  always #(CLK_PERIOD/2) clk = ~clk;

  bit tp [NT];
  bit sp [NS];
  bit en [NS];
  int pr [NS];
  bit alt;
  int m_req, m_vec, m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (tp[t]) tp[t] = 0;
      foreach (sp[i]) begin sp[i] = 0; en[i] = 0; pr[i] = 0; end
      alt = 0; m_req = 0; m_vec = 0; m_addr = 0;
    end else begin
      int w, bp;
      w = -1; bp = 0;
      for (int t = 0; t < NT; t++) if (tp[t] && w < 0) w = t;
      if (w < 0)
        for (int i = 0; i < NS; i++)
          if (sp[i] && en[i] && pr[i] > int'(cpu_ipl) && pr[i] > bp) begin bp = pr[i]; w = NT + i; end
      m_req = (w >= 0);
      if (w >= 0) begin m_vec = w; m_addr = (alt ? 'h104 : 'h4) + 2 * w; end
      if (ack) begin
        if (ack_vec < NT) tp[ack_vec] = 0;
        else if (ack_vec < NT + NS) sp[ack_vec - NT] = 0;
      end
      for (int t = 0; t < NT; t++) if (trap_req[t]) tp[t] = 1;
      for (int i = 0; i < NS; i++) if (irq_req[i]) sp[i] = 1;
      if (cfg_we) begin
        if (cfg_addr == 0) alt = cfg_wdata[15];
        else if (cfg_addr <= NS) begin en[cfg_addr-1] = cfg_wdata[3]; pr[cfg_addr-1] = cfg_wdata[2:0]; end
      end
    end
  end

  task automatic check(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0h exp %0h", t, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/5);
    if (rst_n) begin
      check(tag, "cpu_req", cpu_req, m_req);
      check(tag, "vec_num", vec_num, m_vec);
      check(tag, "vec_addr", vec_addr, m_addr);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = AW'(a); cfg_wdata = 16'(d);
    @(negedge clk); cfg_we = 0;
  endtask
  task automatic girq(int i);
    @(negedge clk); irq_req[i] = 1;
    @(negedge clk); irq_req[i] = 0;
  endtask
  task automatic gtrap(int t);
    @(negedge clk); trap_req[t] = 1;
    @(negedge clk); trap_req[t] = 0;
  endtask
  task automatic gack(int v, int also_irq);
    @(negedge clk); ack = 1; ack_vec = VW'(v);
    if (also_irq >= 0) irq_req[also_irq] = 1;
    @(negedge clk); ack = 0; irq_req = '0;
  endtask
  task automatic expect_out(string t, int r, int v, int a);
    idle(2);
    check(t, "cpu_req", cpu_req, r);
    check(t, "vec_num", vec_num, v);
    check(t, "vec_addr", vec_addr, a);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    idle(3);
    check("R1", "cpu_req", cpu_req, 0);
    check("R1", "vec_num", vec_num, 0);
    check("R1", "vec_addr", vec_addr, 0);
    @(negedge clk); rst_n = 1;

    tag = "R2"; wr(6, 'hB); girq(5);
    expect_out("R2 R6 R7", 1, 13, 'h1E);

    tag = "R4"; @(negedge clk); cpu_ipl = 3;
    expect_out("R4 R10", 0, 13, 'h1E);
    @(negedge clk); cpu_ipl = 0;

    tag = "R5"; wr(3, 'hB); girq(2);
    expect_out("R5 tie", 1, 10, 'h18);
    wr(10, 'hE); girq(9);
    expect_out("R5 prio", 1, 17, 'h26);

    tag = "R3"; @(negedge clk); cpu_ipl = 7; gtrap(4);
    expect_out("R3", 1, 4, 'h0C);
    tag = "R9"; gack(4, -1);
    expect_out("R9 R4", 0, 4, 'h0C);
    @(negedge clk); cpu_ipl = 0;

    tag = "R8"; wr(0, 'h8000);
    expect_out("R8", 1, 17, 'h126);
    gtrap(1); gtrap(3);
    expect_out("R8 R5 trap", 1, 1, 'h106);
    gack(1, -1); gack(3, -1);
    expect_out("R9", 1, 17, 'h126);
    gack(17, -1);
    expect_out("R9 next", 1, 10, 'h118);

    tag = "R11"; wr(3, 'h3);
    expect_out("R11 enable", 1, 13, 'h11E);
    wr(6, 'h8);
    expect_out("R11 R4 prio0", 0, 13, 'h11E);
    wr(NS + 1, 'hF);
    expect_out("R11 unmapped", 0, 13, 'h11E);
    wr(6, 'hB);
    expect_out("R11 reenable", 1, 13, 'h11E);

    tag = "R9"; gack(13, 5);
    expect_out("R9 same-cycle", 1, 13, 'h11E);
    gack(13, -1);
    expect_out("R9 R10", 0, 13, 'h11E);

    tag = "R7"; wr(0, 0); gtrap(0);
    expect_out("R7 R6", 1, 0, 'h4);
    gack(0, -1); idle(3);
    report();
  end
endmodule